// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the host side of a PC-style keyboard controller. The host sees two byte-wide ports selected by a one-bit address. Address 0 is the data port and address 1 is the command/status port. Command bytes written to address 1 are decoded here. The block keeps the controller mode byte, the self-test flag and the output port byte. It drives the A20 gate and a single-cycle CPU reset request.

Any response byte the controller must return to the host is handed out on a push strobe, along with a flag that selects the keyboard-side or the aux-side response queue. The queues live outside this block. Their head bytes and occupancy flags come back in and form the read data and the buffer-full status bits.

Some commands take a second byte. The block latches such a command until the next data-port write, and that write completes it. A data-port write with nothing latched is forwarded to the keyboard device. The serial device protocols, the queue storage and the interrupt logic are all outside this block.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset the mode byte is 0x03, the status read returns 0x18 with both queues empty, the output port holds 0x03 and a20Gate is high.
- R2: Command 0x20 pushes the current mode byte with pushAux low, one cycle after the write.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 push nothing and send nothing. The next data-port write completes the command and clears it, so the data write after that goes to the keyboard device.
- R4: A data-port write with no command pending sends the byte to the device with devToAux low. When 0xD4 is pending, it sends the byte with devToAux high.
- R5: With 0x60 pending, a data write loads the mode byte (shown on modeBits). With 0xD2 pending, it pushes the byte with pushAux low. With 0xD3 pending, it pushes the byte with pushAux high.
- R6: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9, 0xAB and 0xC0 each push 0x00.
- R7: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. No other mode bit changes.
- R8: A command whose upper nibble is 0xF is a pulse command. When its bit 0 is 0, cpuResetReq is high for exactly one cycle. When its bit 0 is 1, nothing happens.
- R9: Command 0xD0 pushes the output port byte. Command 0xDF sets output-port bit 1 and raises a20Gate. Command 0xDD clears bit 1 and lowers a20Gate.
- R10: With 0xD1 pending, a data write loads the output port. a20Gate follows bit 1 of the written byte, and a reset pulse is issued when bit 0 of the written byte is 0.
- R11: A status read returns {2'b00, aux-only pending, 1, 1, self-test, 0, any pending}. A data read returns the aux queue head only when aux data is pending and keyboard data is not; otherwise it returns the keyboard head.
- R12: An unrecognised command byte changes no state, pushes nothing and pulses nothing. It also leaves a pending two-byte command in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle host write strobe |
| addr | input | 1 | Port select: 0 data, 1 command/status |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte (combinational) |
| kbdPend | input | 1 | Keyboard response queue not empty |
| auxPend | input | 1 | Aux response queue not empty |
| kbdHead | input | 8 | Keyboard queue head byte |
| auxHead | input | 8 | Aux queue head byte |
| pushValid | output | 1 | Response byte push strobe |
| pushData | output | 8 | Response byte |
| pushAux | output | 1 | 1 selects aux queue, 0 keyboard queue |
| devValid | output | 1 | Byte to a device strobe |
| devData | output | 8 | Byte to a device |
| devToAux | output | 1 | 1 selects mouse device, 0 keyboard device |
| cpuResetReq | output | 1 | One-cycle CPU reset request |
| a20Gate | output | 1 | A20 gate level (output-port bit 1) |
| modeBits | output | 8 | Current mode byte |

## Verification
The bench checks the whole pulse range, not only 0xFE. If the decoder matched only 0xFE, the bench would see no reset pulse for 0xF0 and 0xFA. If it ignored bit 0, the bench would see a pulse for 0xFF or 0xF3. The bench sends an unrecognised command while a two-byte command is pending. A design that clears the pending opcode on every command write would then send the following data byte to the device instead of pushing it. The bench also writes the output port twice: once with bit 0 set and bit 1 clear, and once the other way round. This exposes a swapped A20 or reset bit. It also drives the aux-only and both-pending cases of the queue flags. A read mux with the wrong priority would return the aux head when both queues hold data.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_RD_MODE   = 8'h20;
  localparam logic [BYTE_W-1:0] OP_WR_MODE   = 8'h60;
  localparam logic [BYTE_W-1:0] OP_AUX_OFF   = 8'hA7;
  localparam logic [BYTE_W-1:0] OP_AUX_ON    = 8'hA8;
  localparam logic [BYTE_W-1:0] OP_AUX_TEST  = 8'hA9;
  localparam logic [BYTE_W-1:0] OP_SELF_TEST = 8'hAA;
  localparam logic [BYTE_W-1:0] OP_KBD_TEST  = 8'hAB;
  localparam logic [BYTE_W-1:0] OP_KBD_OFF   = 8'hAD;
  localparam logic [BYTE_W-1:0] OP_KBD_ON    = 8'hAE;
  localparam logic [BYTE_W-1:0] OP_RD_INPUT  = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_RD_OUTP   = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_WR_OUTP   = 8'hD1;
  localparam logic [BYTE_W-1:0] OP_WR_KBUF   = 8'hD2;
  localparam logic [BYTE_W-1:0] OP_WR_ABUF   = 8'hD3;
  localparam logic [BYTE_W-1:0] OP_WR_AUXDEV = 8'hD4;
  localparam logic [BYTE_W-1:0] OP_GATE_OFF  = 8'hDD;
  localparam logic [BYTE_W-1:0] OP_GATE_ON   = 8'hDF;
  localparam logic [BYTE_W-1:0] OP_CPU_RST   = 8'hFE;
  localparam logic [BYTE_W-1:0] OP_NOP       = 8'hFF;

  localparam logic [BYTE_W-1:0] MODE_INIT  = 8'h03;
  localparam logic [BYTE_W-1:0] OUTP_INIT  = 8'h03;
  localparam logic [BYTE_W-1:0] TEST_PASS  = 8'h55;

  typedef enum logic [1:0] {
    SRC_CONST = 2'd0,
    SRC_MODE  = 2'd1,
    SRC_OUTP  = 2'd2,
    SRC_WDATA = 2'd3
  } pushSrc_e;

  typedef struct packed {
    logic              push;
    logic              pushAux;
    pushSrc_e          pushSrc;
    logic [BYTE_W-1:0] pushConst;
    logic              loadMode;
    logic              setKbdOff;
    logic              clrKbdOff;
    logic              setAuxOff;
    logic              clrAuxOff;
    logic              setSelfTest;
    logic              loadOutPort;
    logic              gateOn;
    logic              gateOff;
    logic              resetReq;
    logic              devSend;
    logic              devAux;
  } ctlStrobe_t;
endpackage

// File: rtl/kbc_ctl.sv
module kbc_ctl
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wrData,
  output ctlStrobe_t        stb
);
  logic [BYTE_W-1:0] pendCmd;
  logic [BYTE_W-1:0] nxtPend;
  logic [BYTE_W-1:0] cmdEff;
  logic              isPulse;

  assign isPulse = (wrData[BYTE_W-1:BYTE_W-4] == 4'hF);
  assign cmdEff  = isPulse ? (wrData[0] ? OP_NOP : OP_CPU_RST) : wrData;

  always_comb begin
    stb     = '0;
    nxtPend = pendCmd;
    if (wrEn && addr) begin
      unique case (cmdEff)
        OP_RD_MODE: begin stb.push = 1'b1; stb.pushSrc = SRC_MODE; end
        OP_WR_MODE, OP_WR_OUTP, OP_WR_KBUF, OP_WR_ABUF, OP_WR_AUXDEV:
          nxtPend = cmdEff;
        OP_AUX_OFF: stb.setAuxOff = 1'b1;
        OP_AUX_ON:  stb.clrAuxOff = 1'b1;
        OP_KBD_OFF: stb.setKbdOff = 1'b1;
        OP_KBD_ON:  stb.clrKbdOff = 1'b1;
        OP_SELF_TEST: begin
          stb.setSelfTest = 1'b1;
          stb.push        = 1'b1;
          stb.pushSrc     = SRC_CONST;
          stb.pushConst   = TEST_PASS;
        end
        OP_AUX_TEST, OP_KBD_TEST, OP_RD_INPUT: begin
          stb.push    = 1'b1;
          stb.pushSrc = SRC_CONST;
        end
        OP_RD_OUTP: begin stb.push = 1'b1; stb.pushSrc = SRC_OUTP; end
        OP_GATE_ON:  stb.gateOn   = 1'b1;
        OP_GATE_OFF: stb.gateOff  = 1'b1;
        OP_CPU_RST:  stb.resetReq = 1'b1;
        default: ;
      endcase
    end else if (wrEn) begin
      nxtPend = '0;
      unique case (pendCmd)
        OP_WR_MODE: stb.loadMode = 1'b1;
        OP_WR_KBUF: begin stb.push = 1'b1; stb.pushSrc = SRC_WDATA; end
        OP_WR_ABUF: begin
          stb.push    = 1'b1;
          stb.pushSrc = SRC_WDATA;
          stb.pushAux = 1'b1;
        end
        OP_WR_OUTP: begin
          stb.loadOutPort = 1'b1;
          stb.resetReq    = ~wrData[0];
        end
        OP_WR_AUXDEV: begin stb.devSend = 1'b1; stb.devAux = 1'b1; end
        default: stb.devSend = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendCmd <= '0;
    else       pendCmd <= nxtPend;
  end

  // R3
  pend_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pendCmd) |-> $past(wrEn));
endmodule

// File: rtl/kbc_dp.sv
module kbc_dp
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              kbdPend,
  input  logic              auxPend,
  input  logic [BYTE_W-1:0] kbdHead,
  input  logic [BYTE_W-1:0] auxHead,
  output logic [BYTE_W-1:0] rdData,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushData,
  output logic              pushAux,
  output logic              devValid,
  output logic [BYTE_W-1:0] devData,
  output logic              devToAux,
  output logic              cpuResetReq,
  output logic              a20Gate,
  output logic [BYTE_W-1:0] modeBits
);
  localparam int KBD_OFF_BIT = 4;
  localparam int AUX_OFF_BIT = 5;
  localparam int GATE_BIT    = 1;

  logic [BYTE_W-1:0] modeReg;
  logic [BYTE_W-1:0] outPort;
  logic              selfTest;
  logic [BYTE_W-1:0] pushSel;
  logic              auxOnly;
  logic [BYTE_W-1:0] statusByte;

  always_comb begin
    unique case (stb.pushSrc)
      SRC_MODE:  pushSel = modeReg;
      SRC_OUTP:  pushSel = outPort;
      SRC_WDATA: pushSel = wrData;
      default:   pushSel = stb.pushConst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg     <= MODE_INIT;
      outPort     <= OUTP_INIT;
      selfTest    <= 1'b0;
      pushValid   <= 1'b0;
      pushData    <= '0;
      pushAux     <= 1'b0;
      devValid    <= 1'b0;
      devData     <= '0;
      devToAux    <= 1'b0;
      cpuResetReq <= 1'b0;
    end else begin
      if (stb.loadMode)       modeReg <= wrData;
      else if (stb.setKbdOff) modeReg[KBD_OFF_BIT] <= 1'b1;
      else if (stb.clrKbdOff) modeReg[KBD_OFF_BIT] <= 1'b0;
      else if (stb.setAuxOff) modeReg[AUX_OFF_BIT] <= 1'b1;
      else if (stb.clrAuxOff) modeReg[AUX_OFF_BIT] <= 1'b0;
      if (stb.loadOutPort)    outPort <= wrData;
      else if (stb.gateOn)    outPort[GATE_BIT] <= 1'b1;
      else if (stb.gateOff)   outPort[GATE_BIT] <= 1'b0;
      if (stb.setSelfTest)    selfTest <= 1'b1;
      pushValid   <= stb.push;
      pushData    <= pushSel;
      pushAux     <= stb.pushAux;
      devValid    <= stb.devSend;
      devData     <= wrData;
      devToAux    <= stb.devAux;
      cpuResetReq <= stb.resetReq;
    end
  end

  assign auxOnly    = auxPend & ~kbdPend;
  assign statusByte = {2'b00, auxOnly, 1'b1, 1'b1, selfTest, 1'b0, kbdPend | auxPend};
  assign rdData     = addr ? statusByte : (auxOnly ? auxHead : kbdHead);
  assign a20Gate    = outPort[GATE_BIT];
  assign modeBits   = modeReg;

  // R7
  mode_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeReg) |-> $past(stb.loadMode | stb.setKbdOff | stb.clrKbdOff |
                                stb.setAuxOff | stb.clrAuxOff));
  // R6
  selftest_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfTest) |-> pushValid && (pushData == TEST_PASS));
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              kbdPend,
  input  logic              auxPend,
  input  logic [BYTE_W-1:0] kbdHead,
  input  logic [BYTE_W-1:0] auxHead,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushData,
  output logic              pushAux,
  output logic              devValid,
  output logic [BYTE_W-1:0] devData,
  output logic              devToAux,
  output logic              cpuResetReq,
  output logic              a20Gate,
  output logic [BYTE_W-1:0] modeBits
);
  ctlStrobe_t stb;

  kbc_ctl ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .stb(stb)
  );

  kbc_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .kbdPend(kbdPend), .auxPend(auxPend), .kbdHead(kbdHead), .auxHead(auxHead),
    .rdData(rdData), .pushValid(pushValid), .pushData(pushData), .pushAux(pushAux),
    .devValid(devValid), .devData(devData), .devToAux(devToAux),
    .cpuResetReq(cpuResetReq), .a20Gate(a20Gate), .modeBits(modeBits)
  );

  // R8
  reset_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetReq |-> $past(wrEn));
  // R2
  push_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> $past(wrEn));
  // R4
  push_dev_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pushValid && devValid));
  // R9
  gate_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(a20Gate) |-> $past(wrEn && !(addr && wrData[7:4] == 4'hF)));
endmodule

// File: tb/kbc_cmd_decoder_tb.sv
module kbc_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic kbdPend = 1'b0;
  logic auxPend = 1'b0;
  logic [7:0] kbdHead = 8'h11;
  logic [7:0] auxHead = 8'h22;
  logic pushValid, pushAux, devValid, devToAux, cpuResetReq, a20Gate;
  logic [7:0] pushData, devData, modeBits;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic cPush, cPAux, cDev, cDAux, cRst;
  logic [7:0] cPData, cDData;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .kbdPend(kbdPend), .auxPend(auxPend), .kbdHead(kbdHead),
    .auxHead(auxHead), .pushValid(pushValid), .pushData(pushData),
    .pushAux(pushAux), .devValid(devValid), .devData(devData),
    .devToAux(devToAux), .cpuResetReq(cpuResetReq), .a20Gate(a20Gate),
    .modeBits(modeBits)
  );

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", what, got, exp);
    end
  endtask

  task automatic wrPort(input logic a, input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = v;
    @(posedge clk); #1;
    cPush = pushValid; cPData = pushData; cPAux = pushAux;
    cDev = devValid; cDData = devData; cDAux = devToAux; cRst = cpuResetReq;
    @(negedge clk);
    wrEn = 1'b0; addr = 1'b1;
  endtask

  task automatic expPush(input string what, input logic [7:0] d, input logic aux);
    chk({what, " push"}, {7'd0, cPush}, 8'd1);
    chk({what, " pushData"}, cPData, d);
    chk({what, " pushAux"}, {7'd0, cPAux}, {7'd0, aux});
  endtask

  task automatic expQuiet(input string what);
    chk({what, " no push"}, {7'd0, cPush}, 8'd0);
    chk({what, " no dev"}, {7'd0, cDev}, 8'd0);
    chk({what, " no reset"}, {7'd0, cRst}, 8'd0);
  endtask

  task automatic readStatus(input string what, input logic [7:0] exp);
    @(negedge clk); addr = 1'b1; #1;
    chk(what, rdData, exp);
  endtask

  task automatic t_reset;
    readStatus("R1 status", 8'h18);
    chk("R1 mode", modeBits, 8'h03);
    chk("R1 a20", {7'd0, a20Gate}, 8'd1);
    chk("R1 reset idle", {7'd0, cpuResetReq}, 8'd0);
    wrPort(1'b1, 8'hD0);
    expPush("R1 outport", 8'h03, 1'b0);
  endtask

  task automatic t_readMode;
    wrPort(1'b1, 8'h20);
    expPush("R2 mode read", 8'h03, 1'b0);
  endtask

  task automatic t_twoPhase;
    wrPort(1'b1, 8'h60); expQuiet("R3 latch 60");
    wrPort(1'b0, 8'h41); expQuiet("R5 load mode");
    chk("R5 modeBits", modeBits, 8'h41);
    wrPort(1'b1, 8'h20); expPush("R5 mode readback", 8'h41, 1'b0);
    wrPort(1'b1, 8'h60); wrPort(1'b0, 8'h03);
    wrPort(1'b1, 8'hD2); expQuiet("R3 latch D2");
    wrPort(1'b0, 8'h5A); expPush("R5 kbd obuf", 8'h5A, 1'b0);
    wrPort(1'b1, 8'hD3); expQuiet("R3 latch D3");
    wrPort(1'b0, 8'hA5); expPush("R5 aux obuf", 8'hA5, 1'b1);
    wrPort(1'b0, 8'h12);
    chk("R3 cleared dev", {7'd0, cDev}, 8'd1);
    chk("R3 cleared dev aux", {7'd0, cDAux}, 8'd0);
    chk("R3 cleared no push", {7'd0, cPush}, 8'd0);
  endtask

  task automatic t_device;
    wrPort(1'b0, 8'h34);
    chk("R4 kbd dev", {7'd0, cDev}, 8'd1);
    chk("R4 kbd data", cDData, 8'h34);
    chk("R4 kbd sel", {7'd0, cDAux}, 8'd0);
    wrPort(1'b1, 8'hD4); expQuiet("R3 latch D4");
    wrPort(1'b0, 8'h99);
    chk("R4 mouse dev", {7'd0, cDev}, 8'd1);
    chk("R4 mouse data", cDData, 8'h99);
    chk("R4 mouse sel", {7'd0, cDAux}, 8'd1);
  endtask

  task automatic t_selfTest;
    readStatus("R6 status before", 8'h18);
    wrPort(1'b1, 8'hAA); expPush("R6 self test", 8'h55, 1'b0);
    readStatus("R6 status after", 8'h1C);
    wrPort(1'b1, 8'hA9); expPush("R6 A9", 8'h00, 1'b0);
    wrPort(1'b1, 8'hAB); expPush("R6 AB", 8'h00, 1'b0);
    wrPort(1'b1, 8'hC0); expPush("R6 C0", 8'h00, 1'b0);
  endtask

  task automatic t_modeBits;
    wrPort(1'b1, 8'hA7); chk("R7 aux off", modeBits, 8'h23);
    wrPort(1'b1, 8'hA8); chk("R7 aux on", modeBits, 8'h03);
    wrPort(1'b1, 8'hAD); chk("R7 kbd off", modeBits, 8'h13);
    wrPort(1'b1, 8'hAE); chk("R7 kbd on", modeBits, 8'h03);
  endtask

  task automatic t_pulse;
    wrPort(1'b1, 8'hF0);
    chk("R8 F0 pulse", {7'd0, cRst}, 8'd1);
    @(posedge clk); #1;
    chk("R8 pulse one cycle", {7'd0, cpuResetReq}, 8'd0);
    wrPort(1'b1, 8'hFE); chk("R8 FE pulse", {7'd0, cRst}, 8'd1);
    wrPort(1'b1, 8'hFA); chk("R8 FA pulse", {7'd0, cRst}, 8'd1);
    wrPort(1'b1, 8'hFF); expQuiet("R8 FF noop");
    wrPort(1'b1, 8'hF3); expQuiet("R8 F3 noop");
    chk("R8 a20 untouched", {7'd0, a20Gate}, 8'd1);
  endtask

  task automatic t_gate;
    wrPort(1'b1, 8'hDD); chk("R9 a20 off", {7'd0, a20Gate}, 8'd0);
    wrPort(1'b1, 8'hD0); expPush("R9 outport after DD", 8'h01, 1'b0);
    wrPort(1'b1, 8'hDF); chk("R9 a20 on", {7'd0, a20Gate}, 8'd1);
    wrPort(1'b1, 8'hD0); expPush("R9 outport after DF", 8'h03, 1'b0);
  endtask

  task automatic t_outPort;
    wrPort(1'b1, 8'hD1); expQuiet("R3 latch D1");
    wrPort(1'b0, 8'h01);
    chk("R10 a20 from bit1", {7'd0, a20Gate}, 8'd0);
    chk("R10 no reset bit0=1", {7'd0, cRst}, 8'd0);
    wrPort(1'b1, 8'hD1);
    wrPort(1'b0, 8'h02);
    chk("R10 a20 set", {7'd0, a20Gate}, 8'd1);
    chk("R10 reset bit0=0", {7'd0, cRst}, 8'd1);
    wrPort(1'b1, 8'hD0); expPush("R10 outport value", 8'h02, 1'b0);
    wrPort(1'b1, 8'hD1); wrPort(1'b0, 8'h03);
    chk("R10 restore no reset", {7'd0, cRst}, 8'd0);
  endtask

  task automatic t_read;
    @(negedge clk); kbdPend = 1'b0; auxPend = 1'b1;
    addr = 1'b0; #1; chk("R11 aux only data", rdData, 8'h22);
    addr = 1'b1; #1; chk("R11 aux only status", rdData, 8'h3D);
    @(negedge clk); kbdPend = 1'b1; auxPend = 1'b1;
    addr = 1'b0; #1; chk("R11 both data", rdData, 8'h11);
    addr = 1'b1; #1; chk("R11 both status", rdData, 8'h1D);
    @(negedge clk); kbdPend = 1'b1; auxPend = 1'b0;
    addr = 1'b0; #1; chk("R11 kbd data", rdData, 8'h11);
    @(negedge clk); kbdPend = 1'b0;
    addr = 1'b1; #1; chk("R11 empty status", rdData, 8'h1C);
  endtask

  task automatic t_unknown;
    wrPort(1'b1, 8'hD2);
    wrPort(1'b1, 8'h11); expQuiet("R12 cmd 11");
    wrPort(1'b1, 8'hB5); expQuiet("R12 cmd B5");
    chk("R12 mode kept", modeBits, 8'h03);
    chk("R12 a20 kept", {7'd0, a20Gate}, 8'd1);
    wrPort(1'b0, 8'h77); expPush("R12 pending kept", 8'h77, 1'b0);
    readStatus("R12 status kept", 8'h1C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_readMode();
    t_twoPhase();
    t_device();
    t_selfTest();
    t_modeBits();
    t_pulse();
    t_gate();
    t_outPort();
    t_read();
    t_unknown();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule